// File: doc/BRIEF.md
# Polled ADC Result Reader

This block is a small read-only bus master. It fetches a conversion result from an ADC that sits somewhere on a simple request/response bus. It works at a steady pace: it waits a programmable number of clock cycles, reads a word from a programmable address and tests one bit of that word as a "result ready" flag. When the flag shows ready, it right-shifts the word and keeps the low 12 bits as a sample. The sample goes out with a one-cycle strobe. When the flag does not show ready, the attempt is dropped and the block waits for the next interval.

The ready flag and the conversion value can come from one word at one address. They can also come from two addresses. In the two-address case, the block first reads the flag word. Only when that word shows ready does it read the value word. The flag's bit position, its polarity, the shift amount and the two addresses are all inputs that can change at run time. The block allows only one read in flight at a time. The gap between attempts is counted from the response that ended the previous attempt.

Top module: `adc_poll_reader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rd_req` and `smp_valid` are 0 and `smp_data` is 0.
- R2: Each attempt starts with a read at `cfg_valid_addr`. While `rd_req` is high and `rd_ack` is low, `rd_req` stays high and `rd_addr` does not change.
- R3: After the clock edge at which a response ends an attempt, the next `rd_req` rises exactly `cfg_interval`+1 clock edges later, provided `poll_en` is high throughout. While `poll_en` is low, no new read is started and the interval count restarts from zero.
- R4: The ready flag is bit `cfg_flag_pos` of the flag word. When `cfg_flag_low` is 0 the flag is ready when that bit is 1. When `cfg_flag_low` is 1 the flag is ready when that bit is 0.
- R5: If the flag word does not show ready, no sample is emitted and no value read is issued. `rd_req` falls at the response edge and the block retries after the interval.
- R6: With `cfg_split` = 0, a ready flag word is also the value word. The sample is emitted in the cycle after its response and `rd_req` falls at that edge.
- R7: With `cfg_split` = 1, a ready flag response is followed directly, at the same edge, by a read at `cfg_volt_addr`. The sample is taken from that second response.
- R8: The sample equals bits [`cfg_shift`+11 : `cfg_shift`] of the value word. Bit positions above 31 read as 0.
- R9: `smp_valid` is high for exactly the one cycle after the response that yields the sample. `smp_data` keeps its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_en | input | 1 | Allows new attempts to start |
| cfg_valid_addr | input | 32 | Address of the flag word |
| cfg_volt_addr | input | 32 | Address of the value word (split mode) |
| cfg_split | input | 1 | 1: flag and value read from separate addresses |
| cfg_flag_pos | input | 5 | Bit position of the ready flag |
| cfg_flag_low | input | 1 | 1: ready flag is active low |
| cfg_shift | input | 5 | Right shift applied to the value word |
| cfg_interval | input | 32 | Idle cycles between attempts |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Read address |
| rd_ack | input | 1 | Response strobe, valid while rd_req is high |
| rd_data | input | 32 | Response word, valid with rd_ack |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 12 | Extracted sample |

## Verification
The hardest case to reach is the split-mode hand-over. In that case `rd_req` must stay high across the acknowledging edge while the address switches to the value word. A responder that always answers with the same latency would hide a late or missing address switch. The bench's responder cycles its latency through 0 to 3 extra cycles, so the value read is answered both at once and after a delay. The flag word is also changed between runs so that it is ready under one polarity and not ready under the other. This drives the no-value-read path on purpose.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

  typedef enum logic [1:0] {
    PS_WAIT = 2'd0,
    PS_FLAG = 2'd1,
    PS_VOLT = 2'd2
  } poll_state_t;

endpackage

// File: rtl/adc_poll_timer.sv
module adc_poll_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] interval,
  output logic             due
);

  logic [CNT_W-1:0] cnt_q;

  assign due = (cnt_q >= interval);

  // The count restarts whenever the controller is not idling with polling enabled.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!due) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_flag_check.sv
module adc_flag_check #(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [POS_W-1:0]  pos,
  input  logic              active_low,
  output logic              ready
);

  logic [DATA_W-1:0] sel_mask;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign sel_mask[g] = (pos == POS_W'(g));
    end
  endgenerate

  assign ready = (|(word & sel_mask)) ^ active_low;

endmodule

// File: rtl/adc_sample_shift.sv
module adc_sample_shift #(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 12,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [SH_W-1:0]   shift,
  output logic [SMP_W-1:0]  sample
);

  logic [DATA_W-1:0] shifted;

  generate
    if (SMP_W > DATA_W) begin : g_wide
      assign shifted = word >> shift;
      assign sample  = SMP_W'(shifted);
    end else begin : g_narrow
      assign shifted = word >> shift;
      assign sample  = shifted[SMP_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/adc_poll_ctrl.sv
module adc_poll_ctrl
  import adc_poll_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic              due,
  input  logic              flag_ready,
  input  logic              cfg_split,
  input  logic [ADDR_W-1:0] cfg_valid_addr,
  input  logic [ADDR_W-1:0] cfg_volt_addr,
  input  logic              rd_ack,
  input  logic [SMP_W-1:0]  sample,
  output logic              timer_run,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              smp_valid,
  output logic [SMP_W-1:0]  smp_data
);

  poll_state_t state_q, state_d;
  logic              req_d;
  logic [ADDR_W-1:0] addr_d;
  logic              sv_d;
  logic [SMP_W-1:0]  sd_d;

  assign timer_run = poll_en && (state_q == PS_WAIT);

  always_comb begin
    state_d = state_q;
    req_d   = rd_req;
    addr_d  = rd_addr;
    sv_d    = 1'b0;
    sd_d    = smp_data;
    unique case (state_q)
      PS_WAIT: begin
        if (poll_en && due) begin
          req_d   = 1'b1;
          addr_d  = cfg_valid_addr;
          state_d = PS_FLAG;
        end
      end
      PS_FLAG: begin
        if (rd_ack) begin
          if (!flag_ready) begin
            req_d   = 1'b0;
            state_d = PS_WAIT;
          end else if (cfg_split) begin
            addr_d  = cfg_volt_addr;
            state_d = PS_VOLT;
          end else begin
            req_d   = 1'b0;
            sv_d    = 1'b1;
            sd_d    = sample;
            state_d = PS_WAIT;
          end
        end
      end
      PS_VOLT: begin
        if (rd_ack) begin
          req_d   = 1'b0;
          sv_d    = 1'b1;
          sd_d    = sample;
          state_d = PS_WAIT;
        end
      end
      default: begin
        req_d   = 1'b0;
        state_d = PS_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_WAIT;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      state_q   <= state_d;
      rd_req    <= req_d;
      rd_addr   <= addr_d;
      smp_valid <= sv_d;
      smp_data  <= sd_d;
    end
  end

endmodule

// File: rtl/adc_poll_reader.sv
module adc_poll_reader #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SMP_W  = 12,
  parameter int CNT_W  = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic [ADDR_W-1:0] cfg_valid_addr,
  input  logic [ADDR_W-1:0] cfg_volt_addr,
  input  logic              cfg_split,
  input  logic [POS_W-1:0]  cfg_flag_pos,
  input  logic              cfg_flag_low,
  input  logic [POS_W-1:0]  cfg_shift,
  input  logic [CNT_W-1:0]  cfg_interval,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              smp_valid,
  output logic [SMP_W-1:0]  smp_data
);

  logic             due;
  logic             timer_run;
  logic             flag_ready;
  logic [SMP_W-1:0] sample;

  adc_poll_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (timer_run),
    .interval (cfg_interval),
    .due      (due)
  );

  adc_flag_check #(.DATA_W(DATA_W)) i_flag (
    .word       (rd_data),
    .pos        (cfg_flag_pos),
    .active_low (cfg_flag_low),
    .ready      (flag_ready)
  );

  adc_sample_shift #(.DATA_W(DATA_W), .SMP_W(SMP_W)) i_shift (
    .word   (rd_data),
    .shift  (cfg_shift),
    .sample (sample)
  );

  adc_poll_ctrl #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) i_ctrl (
    .clk            (clk),
    .rst            (rst),
    .poll_en        (poll_en),
    .due            (due),
    .flag_ready     (flag_ready),
    .cfg_split      (cfg_split),
    .cfg_valid_addr (cfg_valid_addr),
    .cfg_volt_addr  (cfg_volt_addr),
    .rd_ack         (rd_ack),
    .sample         (sample),
    .timer_run      (timer_run),
    .rd_req         (rd_req),
    .rd_addr        (rd_addr),
    .smp_valid      (smp_valid),
    .smp_data       (smp_data)
  );

endmodule

// File: rtl/adc_poll_reader_chk.sv
module adc_poll_reader_chk #(
  parameter int ADDR_W = 32,
  parameter int SMP_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              poll_en,
  input logic              cfg_split,
  input logic [ADDR_W-1:0] cfg_volt_addr,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_data
);

  // R2: an unanswered request is held with a steady address
  a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R3: with polling disabled, an idle bus stays idle
  a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    !poll_en && !rd_req |=> !rd_req);

  // R6: in single-address mode every response ends the request
  a_r6_single_ends: assert property (@(posedge clk) disable iff (rst)
    $past(rd_req && rd_ack && !cfg_split) |-> !rd_req);

  // R7: a request that continues past a response targets the value address
  a_r7_volt_follow: assert property (@(posedge clk) disable iff (rst)
    rd_req && $past(rd_req && rd_ack) |-> rd_addr == cfg_volt_addr);

  // R9: strobe only right after an answered request
  a_r9_strobe_after_ack: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(rd_req && rd_ack));

  // R9: sample holds between strobes
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> $stable(smp_data));

endmodule

bind adc_poll_reader adc_poll_reader_chk #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .poll_en       (poll_en),
  .cfg_split     (cfg_split),
  .cfg_volt_addr (cfg_volt_addr),
  .rd_req        (rd_req),
  .rd_ack        (rd_ack),
  .rd_addr       (rd_addr),
  .smp_valid     (smp_valid),
  .smp_data      (smp_data)
);

// File: tb/test_adc_poll_reader.sv
`timescale 1ns/1ps
module test_adc_poll_reader;

  logic        clk = 1'b0;
  logic        rst;
  logic        poll_en;
  logic [31:0] cfg_valid_addr, cfg_volt_addr;
  logic        cfg_split;
  logic [4:0]  cfg_flag_pos;
  logic        cfg_flag_low;
  logic [4:0]  cfg_shift;
  logic [31:0] cfg_interval;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        smp_valid;
  logic [11:0] smp_data;

  logic [31:0] flag_word, value_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_poll_reader i_adc_poll_reader (
    .clk(clk), .rst(rst), .poll_en(poll_en),
    .cfg_valid_addr(cfg_valid_addr), .cfg_volt_addr(cfg_volt_addr),
    .cfg_split(cfg_split), .cfg_flag_pos(cfg_flag_pos), .cfg_flag_low(cfg_flag_low),
    .cfg_shift(cfg_shift), .cfg_interval(cfg_interval),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  // Behavioural reference model, advanced on every rising edge.
  int          m_st;
  longint      m_cnt;
  bit          e_req, e_sv;
  logic [31:0] e_addr;
  logic [11:0] e_sd;

  function automatic bit flag_of(input logic [31:0] w);
    return ((w >> cfg_flag_pos) & 32'd1) != {31'd0, cfg_flag_low};
  endfunction

  function automatic logic [11:0] smp_of(input logic [31:0] w);
    longint v;
    v = longint'(w) >> cfg_shift;
    return v[11:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; e_req = 0; e_sv = 0; e_addr = 0; e_sd = 0;
    end else begin
      e_sv = 0;
      if (m_st == 0) begin
        if (!poll_en) m_cnt = 0;
        else if (m_cnt >= longint'(cfg_interval)) begin
          e_req = 1; e_addr = cfg_valid_addr; m_st = 1;
        end else m_cnt = m_cnt + 1;
      end else if (m_st == 1) begin
        m_cnt = 0;
        if (rd_ack) begin
          if (!flag_of(rd_data)) begin
            e_req = 0; m_st = 0;
          end else if (cfg_split) begin
            e_addr = cfg_volt_addr; m_st = 2;
          end else begin
            e_req = 0; e_sv = 1; e_sd = smp_of(rd_data); m_st = 0;
          end
        end
      end else begin
        m_cnt = 0;
        if (rd_ack) begin
          e_req = 0; e_sv = 1; e_sd = smp_of(rd_data); m_st = 0;
        end
      end
    end
  end

  // Responder: answers after 0..3 extra cycles, latency rotating per request.
  initial begin
    int wait_n = 0;
    int lat = 0;
    rd_ack = 0; rd_data = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 0;
      end else if (rd_req) begin
        if (wait_n == 0) begin
          rd_ack  = 1;
          rd_data = (rd_addr == cfg_volt_addr) ? value_word : flag_word;
          lat     = lat + 1;
          wait_n  = lat % 4;
        end else begin
          wait_n = wait_n - 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  int strobes;
  logic [11:0] last_smp;

  // Compare the design against the model for n cycles, counting strobes.
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rd_req == e_req, "R3 rd_req", rd_req, e_req);
      if (e_req) check(rd_addr == e_addr, "R2/R7 rd_addr", rd_addr, e_addr);
      check(smp_valid == e_sv, "R9 smp_valid", smp_valid, e_sv);
      check(smp_data == e_sd, "R8 smp_data", smp_data, e_sd);
      if (smp_valid) begin strobes++; last_smp = smp_data; end
    end
  endtask

  task automatic quiesce();
    poll_en = 0;
    run(20);
    strobes = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; poll_en = 0; cfg_valid_addr = 32'h0000_1000; cfg_volt_addr = 32'h0000_2000;
    cfg_split = 0; cfg_flag_pos = 5'd16; cfg_flag_low = 0; cfg_shift = 5'd4;
    cfg_interval = 32'd5; flag_word = 32'h0001_ABCD; value_word = 32'h00FE_DCBA;
    strobes = 0; last_smp = 0;
    repeat (3) @(negedge clk);
    check(!rd_req && !smp_valid && smp_data == 0, "R1 reset", {rd_req, smp_valid, smp_data}, 0);
    rst = 0;
    @(negedge clk);
    check(!rd_req && !smp_valid && smp_data == 0, "R1 after reset", {rd_req, smp_valid, smp_data}, 0);

    // R6 / R8: single address, active high flag at bit 16, shift 4
    poll_en = 1; strobes = 0;
    run(120);
    check(strobes >= 3, "R6 strobe count", strobes, 3);
    check(last_smp == 12'hABC, "R6 sample", last_smp, 12'hABC);
    quiesce();

    // R4: active low flag, bit 16 clear, no shift
    cfg_flag_low = 1; cfg_shift = 0; flag_word = 32'h0000_1234;
    poll_en = 1; run(120);
    check(strobes >= 3, "R4 strobe count", strobes, 3);
    check(last_smp == 12'h234, "R4 sample", last_smp, 12'h234);
    quiesce();

    // R5: flag not ready (active high, bit clear) in split mode: no sample, no value read
    cfg_flag_low = 0; cfg_split = 1; cfg_interval = 3;
    poll_en = 1; run(120);
    check(strobes == 0, "R5 no sample", strobes, 0);
    quiesce();

    // R7: split mode, flag at bit 31, value word shifted by 8
    cfg_flag_pos = 5'd31; flag_word = 32'h8000_0000; cfg_shift = 5'd8;
    poll_en = 1; run(150);
    check(strobes >= 3, "R7 strobe count", strobes, 3);
    check(last_smp == 12'hEDC, "R7 sample", last_smp, 12'hEDC);
    quiesce();

    // R8: large shift reaches past the top bit
    cfg_split = 0; cfg_flag_pos = 0; flag_word = 32'hF000_0001; cfg_shift = 5'd28;
    cfg_interval = 0; poll_en = 1; run(60);
    check(last_smp == 12'h00F, "R8 high shift", last_smp, 12'h00F);
    quiesce();

    // R3: disabled polling issues no request
    cfg_interval = 0; poll_en = 0; run(40);
    check(!rd_req && strobes == 0, "R3 disabled idle", rd_req, 0);

    // R3: long interval spacing under enable
    cfg_interval = 40; poll_en = 1; run(200);
    check(strobes >= 3, "R3 long interval", strobes, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule